// File: doc/BRIEF.md
# Dual-Loop Out-of-Lock Detector

This block watches two phase-locked loops and decides, for each one, whether it is in lock. Each loop delivers two single-cycle strobes: one from its reference divider and one from its main divider. The block runs on a sampling clock that stands in for the loop's RF input. It counts the sampling-clock cycles between the earlier and the later strobe of each comparison, and that count is the phase error. A comparison whose error exceeds the threshold marks the loop as out of lock. A comparison whose second strobe never arrives within the threshold is also bad. Once a loop is flagged, the flag is released only after a run of consecutive good comparisons. This hysteresis keeps the status from chattering around the lock point.

A shared status pin is modelled as an open-drain driver, where output value 1 means released (high impedance) and 0 means pulled low. A 2-bit select chooses what controls the pin: a general-purpose port bit, the status of loop B, the status of loop A, or the OR of both statuses. Each loop has a power enable. A powered-down loop holds its flag cleared. Powering a loop up puts it into a hunting state where it is flagged until it proves lock.

Each loop has a measuring state machine with three states:
- IDLE: waiting for the first strobe.
- REF_LEAD: the reference strobe came first.
- DIV_LEAD: the divider strobe came first.

Its transitions are:
- open: the first strobe moves IDLE to a lead state.
- close: the opposite strobe returns the machine to IDLE with a good result.
- timeout: the count reaches the threshold with no closing strobe, which returns to IDLE with a bad result.
- reopen: a strobe of the leading kind arrives together with a close or a timeout, which starts a new window in the same lead state.

Each loop also has a lock-tracking state machine with three states:
- OFF: powered down.
- HUNT: flagged, counting good comparisons.
- LOCKED: flag clear.

Its transitions are:
- power-up: OFF to HUNT.
- power-down: any state to OFF.
- lock: HUNT to LOCKED on the last good comparison of a run.
- slip: LOCKED to HUNT on a bad comparison.
- restart: a bad comparison in HUNT clears the run count.

Top module: `dual_lock_monitor`

## Requirements
- R1: After reset both loops are in OFF with their flags clear, and status_pin is 1 (released).
- R2: The phase error is the number of sampling-clock cycles from the first strobe to the second, counted in either order. An error of at most THRESH (default 80) is a good comparison. Two strobes in the same cycle give an error of 0.
- R3: A comparison is bad when its second strobe has not arrived after THRESH cycles, so any error above THRESH is bad. A bad comparison sets that loop's flag at once.
- R4: A flagged loop clears its flag only after GOOD_RUN (default 8) consecutive good comparisons. Any bad comparison restarts the run from zero.
- R5: While its power enable is 0, a loop keeps its flag clear and its run count at zero, and its strobes have no effect. When the enable goes to 1, the loop enters HUNT with its flag set.
- R6: With sel = 2'b00, status_pin follows port_bit. A value of 1 is released and 0 is pulled low, whatever the loop flags are.
- R7: With sel = 2'b01, status_pin is 0 exactly when loop B is flagged. With sel = 2'b10, status_pin is 0 exactly when loop A is flagged.
- R8: With sel = 2'b11, status_pin is 0 when either loop is flagged and 1 only when neither is.
- R9: The two loops are independent: strobes, errors and power on one loop never change the other loop's flag.
- R10: status_pin is registered and shows the select, port bit and flags of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock standing for the RF input |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_a | input | 1 | Loop A power enable (1 = running) |
| pwr_b | input | 1 | Loop B power enable (1 = running) |
| ref_a | input | 1 | Loop A reference-divider strobe, one cycle |
| div_a | input | 1 | Loop A main-divider strobe, one cycle |
| ref_b | input | 1 | Loop B reference-divider strobe, one cycle |
| div_b | input | 1 | Loop B main-divider strobe, one cycle |
| sel | input | 2 | Pin source: 00 port, 01 loop B, 10 loop A, 11 either loop |
| port_bit | input | 1 | General-purpose pin value in port mode (1 = released) |
| status_pin | output | 1 | Open-drain style pin: 1 released, 0 pulled low |

## Verification
The bench builds the block with THRESH = 20 and GOOD_RUN = 8. The short threshold brings the 20-versus-21-cycle boundary, the missing-strobe timeout and the tail windows that a late strobe opens within a few dozen cycles each. Keeping GOOD_RUN at its default value exercises the real hysteresis length, including a run broken after five good comparisons. Every select value is observed while the two loops hold different flags, so each source of the pin can be told apart from the others.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;

    // Phase-window measuring machine
    typedef enum logic [1:0] {
        M_IDLE     = 2'd0,
        M_REF_LEAD = 2'd1,
        M_DIV_LEAD = 2'd2
    } meas_state_t;

    // Lock hysteresis machine
    typedef enum logic [1:0] {
        H_OFF    = 2'd0,
        H_HUNT   = 2'd1,
        H_LOCKED = 2'd2
    } hyst_state_t;

    // Status pin source, encoding decoded from the select input
    typedef enum logic [1:0] {
        SEL_PORT   = 2'b00,
        SEL_LOOP_B = 2'b01,
        SEL_LOOP_A = 2'b10,
        SEL_EITHER = 2'b11
    } pin_sel_t;

    localparam int NUM_LOOPS = 2;

endpackage

// File: rtl/lockmon_phase_meas.sv
module lockmon_phase_meas
    import lockmon_pkg::*;
#(
    parameter int THRESH = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    input  logic ref_stb,
    input  logic div_stb,
    output logic cmp_done,
    output logic cmp_bad
);

    localparam int              TW    = $clog2(THRESH + 1);
    localparam logic [TW-1:0]   LIMIT = TW'(THRESH);
    localparam logic [TW-1:0]   ONE   = TW'(1);

    meas_state_t   st_q, st_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic          at_limit;

    assign at_limit = (cnt_q == LIMIT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= M_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state and window count
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!pwr_en) begin
            st_d  = M_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                M_IDLE: begin
                    if (ref_stb && !div_stb) begin
                        st_d  = M_REF_LEAD;
                        cnt_d = ONE;
                    end else if (div_stb && !ref_stb) begin
                        st_d  = M_DIV_LEAD;
                        cnt_d = ONE;
                    end
                end
                M_REF_LEAD: begin
                    if (div_stb || at_limit) begin
                        if (ref_stb) begin
                            st_d  = M_REF_LEAD;
                            cnt_d = ONE;
                        end else begin
                            st_d  = M_IDLE;
                            cnt_d = '0;
                        end
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                M_DIV_LEAD: begin
                    if (ref_stb || at_limit) begin
                        if (div_stb) begin
                            st_d  = M_DIV_LEAD;
                            cnt_d = ONE;
                        end else begin
                            st_d  = M_IDLE;
                            cnt_d = '0;
                        end
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                default: begin
                    st_d  = M_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // Comparison result outputs
    always_comb begin
        cmp_done = 1'b0;
        cmp_bad  = 1'b0;
        if (pwr_en) begin
            unique case (st_q)
                M_IDLE: begin
                    cmp_done = ref_stb && div_stb;
                end
                M_REF_LEAD: begin
                    cmp_done = div_stb || at_limit;
                    cmp_bad  = !div_stb && at_limit;
                end
                M_DIV_LEAD: begin
                    cmp_done = ref_stb || at_limit;
                    cmp_bad  = !ref_stb && at_limit;
                end
                default: begin
                    cmp_done = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/lockmon_hyst.sv
module lockmon_hyst
    import lockmon_pkg::*;
#(
    parameter int GOOD_RUN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    input  logic cmp_done,
    input  logic cmp_bad,
    output logic oolf
);

    localparam int            CW   = (GOOD_RUN > 1) ? $clog2(GOOD_RUN) : 1;
    localparam logic [CW-1:0] LAST = CW'(GOOD_RUN - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    hyst_state_t   st_q, st_d;
    logic [CW-1:0] run_q, run_d;
    logic          good, bad;

    assign good = cmp_done && !cmp_bad;
    assign bad  = cmp_done && cmp_bad;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= H_OFF;
            run_q <= '0;
        end else begin
            st_q  <= st_d;
            run_q <= run_d;
        end
    end

    // Next state and good-run count
    always_comb begin
        st_d  = st_q;
        run_d = run_q;
        if (!pwr_en) begin
            st_d  = H_OFF;
            run_d = '0;
        end else begin
            unique case (st_q)
                H_OFF: begin
                    st_d  = H_HUNT;
                    run_d = '0;
                end
                H_HUNT: begin
                    if (bad) begin
                        run_d = '0;
                    end else if (good) begin
                        if (run_q == LAST) begin
                            st_d  = H_LOCKED;
                            run_d = '0;
                        end else begin
                            run_d = run_q + ONE;
                        end
                    end
                end
                H_LOCKED: begin
                    if (bad) begin
                        st_d  = H_HUNT;
                        run_d = '0;
                    end
                end
                default: begin
                    st_d  = H_OFF;
                    run_d = '0;
                end
            endcase
        end
    end

    // Flag output
    always_comb begin
        unique case (st_q)
            H_HUNT:  oolf = 1'b1;
            default: oolf = 1'b0;
        endcase
    end

endmodule

// File: rtl/lockmon_pin_mux.sv
module lockmon_pin_mux
    import lockmon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           sel,
    input  logic                 port_bit,
    input  logic [NUM_LOOPS-1:0] oolf,
    output logic                 pin
);

    logic pull_d;
    logic pin_q;

    // Pull-down request: 1 turns the output transistor on
    always_comb begin
        unique case (pin_sel_t'(sel))
            SEL_PORT:   pull_d = !port_bit;
            SEL_LOOP_B: pull_d = oolf[1];
            SEL_LOOP_A: pull_d = oolf[0];
            SEL_EITHER: pull_d = |oolf;
            default:    pull_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b1;
        end else begin
            pin_q <= !pull_d;
        end
    end

    assign pin = pin_q;

endmodule

// File: rtl/dual_lock_monitor.sv
module dual_lock_monitor
    import lockmon_pkg::*;
#(
    parameter int THRESH   = 80,
    parameter int GOOD_RUN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_a,
    input  logic       pwr_b,
    input  logic       ref_a,
    input  logic       div_a,
    input  logic       ref_b,
    input  logic       div_b,
    input  logic [1:0] sel,
    input  logic       port_bit,
    output logic       status_pin
);

    logic [NUM_LOOPS-1:0] pwr_vec;
    logic [NUM_LOOPS-1:0] ref_vec;
    logic [NUM_LOOPS-1:0] div_vec;
    logic [NUM_LOOPS-1:0] done_vec;
    logic [NUM_LOOPS-1:0] bad_vec;
    logic [NUM_LOOPS-1:0] oolf_vec;

    assign pwr_vec = {pwr_b, pwr_a};
    assign ref_vec = {ref_b, ref_a};
    assign div_vec = {div_b, div_a};

    for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_loop
        lockmon_phase_meas #(
            .THRESH(THRESH)
        ) u_meas (
            .clk     (clk),
            .rst_n   (rst_n),
            .pwr_en  (pwr_vec[i]),
            .ref_stb (ref_vec[i]),
            .div_stb (div_vec[i]),
            .cmp_done(done_vec[i]),
            .cmp_bad (bad_vec[i])
        );

        lockmon_hyst #(
            .GOOD_RUN(GOOD_RUN)
        ) u_hyst (
            .clk     (clk),
            .rst_n   (rst_n),
            .pwr_en  (pwr_vec[i]),
            .cmp_done(done_vec[i]),
            .cmp_bad (bad_vec[i]),
            .oolf    (oolf_vec[i])
        );
    end

    lockmon_pin_mux u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .port_bit(port_bit),
        .oolf    (oolf_vec),
        .pin     (status_pin)
    );

endmodule

// File: rtl/dual_lock_monitor_chk.sv
module dual_lock_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sel,
    input logic       port_bit,
    input logic       status_pin,
    input logic [1:0] pwr,
    input logic [1:0] done,
    input logic [1:0] bad,
    input logic [1:0] oolf
);

    for (genvar i = 0; i < 2; i++) begin : g_chk
        // R3
        bad_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr[i] && done[i] && bad[i]) |=> oolf[i]);

        // R5
        off_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pwr[i] |=> !oolf[i]);

        // R4
        release_on_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(oolf[i]) && $past(pwr[i])) |-> $past(done[i] && !bad[i]));

        // R5
        powerup_hunts_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwr[i]) |=> oolf[i]);
    end

    // R6
    port_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |=> (status_pin == $past(port_bit)));

    // R7
    loop_a_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b10) |=> (status_pin == !$past(oolf[0])));

    // R7
    loop_b_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b01) |=> (status_pin == !$past(oolf[1])));

    // R8
    either_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b11 && (oolf != 2'b00)) |=> !status_pin);

endmodule

bind dual_lock_monitor dual_lock_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .port_bit  (port_bit),
    .status_pin(status_pin),
    .pwr       (pwr_vec),
    .done      (done_vec),
    .bad       (bad_vec),
    .oolf      (oolf_vec)
);

// File: tb/dual_lock_monitor_tb.sv
`timescale 1ns/1ps
module dual_lock_monitor_tb;

    localparam int THRESH   = 20;
    localparam int GOOD_RUN = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_a = 1'b0, pwr_b = 1'b0;
    logic       ref_a = 1'b0, div_a = 1'b0, ref_b = 1'b0, div_b = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       port_bit = 1'b1;
    logic       status_pin;

    int    compared = 0;
    int    mismatched = 0;
    bit    exp_q[$];
    string tag_q[$];
    bit    done_flag = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dual_lock_monitor #(.THRESH(THRESH), .GOOD_RUN(GOOD_RUN)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_a(pwr_a), .pwr_b(pwr_b),
        .ref_a(ref_a), .div_a(div_a), .ref_b(ref_b), .div_b(div_b),
        .sel(sel), .port_bit(port_bit), .status_pin(status_pin)
    );

    // Monitor: pops expected items and compares away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                compared++;
                if (status_pin !== e) begin
                    mismatched++;
                    $display("FAIL %s: status_pin actual %b expected %b", t, status_pin, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            mismatched++;
            $display("FAIL watchdog: run actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic drive(input bit lp, input bit r, input bit d);
        if (lp) begin ref_b = r; div_b = d; end
        else    begin ref_a = r; div_a = d; end
    endtask

    // One comparison: leading strobe, then the other gap cycles later
    task automatic cmp(input bit lp, input bit ref_first, input int gap);
        @(negedge clk);
        if (gap == 0) drive(lp, 1'b1, 1'b1);
        else          drive(lp, ref_first, !ref_first);
        @(negedge clk);
        drive(lp, 1'b0, 1'b0);
        if (gap > 0) begin
            repeat (gap - 1) @(negedge clk);
            drive(lp, !ref_first, ref_first);
            @(negedge clk);
            drive(lp, 1'b0, 1'b0);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic good_run(input bit lp, input int n, input int gap, input bit ref_first);
        for (int k = 0; k < n; k++) cmp(lp, ref_first, gap);
    endtask

    // Reference strobe with no divider strobe: a timeout
    task automatic lone(input bit lp);
        @(negedge clk);
        drive(lp, 1'b1, 1'b0);
        @(negedge clk);
        drive(lp, 1'b0, 1'b0);
        repeat (THRESH + 5) @(negedge clk);
    endtask

    task automatic flush();
        repeat (2 * THRESH + 10) @(negedge clk);
    endtask

    // Driver side of the scoreboard: push the expected pin value
    task automatic expect_pin(input bit e, input string tag);
        repeat (2) @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        expect_pin(1'b1, "R1 reset pin released");
        sel = 2'b10; expect_pin(1'b1, "R1 loop A flag clear after reset");
        sel = 2'b01; expect_pin(1'b1, "R1 loop B flag clear after reset");

        sel = 2'b00; port_bit = 1'b0; expect_pin(1'b0, "R6 port 0 pulls low");
        port_bit = 1'b1; expect_pin(1'b1, "R6 port 1 released");
        port_bit = 1'b0; sel = 2'b10; expect_pin(1'b1, "R10 pin follows select change");

        cmp(1'b0, 1'b1, THRESH + 5); flush();
        expect_pin(1'b1, "R5 powered-down loop ignores bad comparison");

        pwr_a = 1'b1; expect_pin(1'b0, "R5 power-up enters hunting flagged");
        good_run(1'b0, GOOD_RUN - 1, 5, 1'b1);
        expect_pin(1'b0, "R4 seven good comparisons still flagged");
        cmp(1'b0, 1'b1, 5);
        expect_pin(1'b1, "R4 eighth good comparison clears flag");

        cmp(1'b0, 1'b1, THRESH + 1); flush();
        expect_pin(1'b0, "R3 error THRESH+1 sets flag");
        good_run(1'b0, 4, THRESH, 1'b1);
        good_run(1'b0, 3, THRESH, 1'b0);
        expect_pin(1'b0, "R2 seven boundary comparisons still flagged");
        cmp(1'b0, 1'b1, 0);
        expect_pin(1'b1, "R2 error THRESH either order and simultaneous are good");

        lone(1'b0);
        expect_pin(1'b0, "R3 missing divider strobe sets flag");
        good_run(1'b0, 5, 3, 1'b1);
        cmp(1'b0, 1'b0, THRESH + 10); flush();
        good_run(1'b0, GOOD_RUN - 1, 3, 1'b0);
        expect_pin(1'b0, "R4 bad comparison restarts the run");
        cmp(1'b0, 1'b0, 3);
        expect_pin(1'b1, "R4 full run after restart clears flag");

        pwr_b = 1'b1; sel = 2'b01;
        expect_pin(1'b0, "R7 loop B hunting pulls pin low");
        sel = 2'b10; expect_pin(1'b1, "R9 loop A unaffected by loop B power-up");
        good_run(1'b1, GOOD_RUN, 7, 1'b1);
        sel = 2'b01; expect_pin(1'b1, "R7 loop B locked releases pin");

        lone(1'b0);
        sel = 2'b10; expect_pin(1'b0, "R7 loop A flagged pulls pin low");
        sel = 2'b01; expect_pin(1'b1, "R9 loop B unaffected by loop A error");
        sel = 2'b11; expect_pin(1'b0, "R8 either mode with loop A flagged");
        good_run(1'b0, GOOD_RUN, 2, 1'b1);
        expect_pin(1'b1, "R8 either mode with both locked");
        lone(1'b1);
        expect_pin(1'b0, "R8 either mode with loop B flagged");

        pwr_b = 1'b0;
        expect_pin(1'b1, "R5 powering down loop B clears its flag");
        sel = 2'b01; expect_pin(1'b1, "R5 loop B off reads clear");
        pwr_b = 1'b1; expect_pin(1'b0, "R5 loop B repowered hunts");
        sel = 2'b00; port_bit = 1'b1;
        expect_pin(1'b1, "R6 port mode ignores loop B flag");

        while (exp_q.size() > 0) @(negedge clk);
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule